// File: doc/BRIEF.md
# IQ Mismatch Coefficient Calculator

This block estimates the receive IQ imbalance of a single chain and turns it into two signed 7-bit correction coefficients. The first coefficient corrects phase and scales I into Q. The second corrects gain and scales Q into Q. A start pulse opens a collection window. Every valid beat on the measurement stream carries one sample of I power, Q power and signed IQ correlation, and the block adds each of the three into its own 32-bit accumulator. The window closes after a programmed number of measurement intervals. The length of one interval, in beats, is set by a logarithmic count.

When the window closes, the block normalises the sums. The phase denominator is the half-sum of I and Q power divided by 256. The gain denominator is Q power divided by 64. A restoring divider produces one quotient bit per cycle and runs twice: once for the phase quotient and once for the gain quotient. The block then clamps both results, applies the sign convention and registers the coefficients. If either denominator is zero, the calculation is skipped and the previous coefficients stay in place.

The controller has seven states. IDLE waits for start. COLLECT accumulates beats. PREP checks the denominators. DIV_PH runs the phase division. DIV_GN runs the gain division. FINISH registers the coefficients. SKIP reports a zero denominator. The transitions are:
- start moves any state to COLLECT.
- COLLECT goes to PREP on the last beat of the last interval.
- PREP goes to SKIP when a denominator is zero, and to DIV_PH otherwise.
- DIV_PH goes to DIV_GN when the divider returns a quotient.
- DIV_GN goes to FINISH when the divider returns a quotient.
- FINISH and SKIP return to IDLE.

Top module: `iqc_calc`

## Requirements
- R1: While reset is held and right after it is released, both coefficients are zero, and done, skipped and corr_en are all low.
- R2: A start pulse restarts collection from any state. It clears all three accumulators and latches log_cnt and num_meas. Later changes on those inputs have no effect until the next start. A beat is taken only in COLLECT with in_valid high and start low.
- R3: One interval is 2^(log_cnt+1) accepted beats. Collection ends on the last beat of interval num_meas. A num_meas of 0 counts as 1.
- R4: Each accumulator is 32 bits wide and wraps modulo 2^32.
- R5: The summed correlation is read as 32-bit two's complement. If its unsigned value is greater than 0x80000000, the block uses its negation as the magnitude and treats it as negative. The value exactly 0x80000000 is used as it is and counts as non-negative.
- R6: The phase denominator is (I/2 + Q/2)/256 and the gain denominator is Q/64, using the summed powers and truncating unsigned division. The divider is never started with a zero divisor.
- R7: If either denominator is zero, done and skipped pulse together 2 rising edges after the edge that takes the last beat. The coefficients and corr_en keep their values.
- R8: The phase coefficient is min(magnitude / phase denominator, 63), negated when the correlation is non-negative.
- R9: The gain coefficient is (I power / gain denominator) − 64, clamped to the range −63 to +63.
- R10: Each coefficient is driven as the low 7 bits of its two's-complement value, so −63 appears as 0x41. The value 0x40 never appears. The coefficients change only in a cycle in which done is high.
- R11: On a successful calculation, done is high for exactly one cycle. It rises 68 rising edges after the edge that takes the last beat, which covers two 32-cycle divisions. The new coefficients are visible in that same cycle.
- R12: corr_en goes high together with the first successful done and stays high until reset. A skipped calculation does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle pulse that begins a new collection |
| log_cnt | input | 4 | Interval length code; one interval is 2^(log_cnt+1) beats |
| num_meas | input | 8 | Number of intervals to collect (0 counts as 1) |
| in_valid | input | 1 | Qualifies the three measurement inputs |
| in_pwr_i | input | 32 | I power sample |
| in_pwr_q | input | 32 | Q power sample |
| in_corr | input | 32 | Signed IQ correlation sample |
| coef_phase | output | 7 | Phase (I-into-Q) coefficient, two's complement |
| coef_gain | output | 7 | Gain (Q-into-Q) coefficient, two's complement |
| corr_en | output | 1 | Correction enable; sticky after the first successful calculation |
| done | output | 1 | One-cycle completion pulse |
| skipped | output | 1 | Pulses with done when a denominator was zero |

## Verification
Every result is timed from the rising edge that takes the final beat of the window. A skip reports on the 2nd edge after it. A full calculation reports on the 68th edge after it, made up of one PREP cycle, two 32-cycle divisions, one capture cycle each and the FINISH cycle. The bench counts edges from that reference edge, sampling 1 ns after each edge, and checks the edge count at which done first appears against these figures. It checks that done is low again one edge later. It reads the coefficients in the cycle where done was seen. A partial window is also held for 80 cycles, to confirm that no result appears before the last beat of the last interval.

// File: rtl/iqc_pkg.sv
package iqc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_PREP    = 3'd2,
        ST_DIV_PH  = 3'd3,
        ST_DIV_GN  = 3'd4,
        ST_FINISH  = 3'd5,
        ST_SKIP    = 3'd6
    } iqc_state_e;

    localparam int NUM_ACC = 3;
    localparam int ACC_PI  = 0;
    localparam int ACC_PQ  = 1;
    localparam int ACC_CR  = 2;

endpackage

// File: rtl/iqc_accum.sv
module iqc_accum #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] sum
);

    // Wrapping accumulator; clear wins over add.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum <= '0;
        end else if (en) begin
            sum <= sum + din;
        end
    end

endmodule

// File: rtl/iqc_divider.sv
module iqc_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         valid
);

    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  div_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    partial;
    logic [W+1:0]  trial;
    logic          fits;

    // One restoring step: bring down the next dividend bit and try a subtract.
    always_comb begin
        partial = {rem_q, quotient[W-1]};
        trial   = {1'b0, partial} - {2'b00, div_q};
        fits    = ~trial[W+1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            div_q    <= '0;
            quotient <= '0;
            cnt_q    <= '0;
            valid    <= 1'b0;
        end else if (start) begin
            rem_q    <= '0;
            div_q    <= divisor;
            quotient <= dividend;
            cnt_q    <= CW'(W);
            valid    <= 1'b0;
        end else if (cnt_q != '0) begin
            rem_q    <= fits ? trial[W-1:0] : partial[W-1:0];
            quotient <= {quotient[W-2:0], fits};
            cnt_q    <= cnt_q - CW'(1);
            valid    <= (cnt_q == CW'(1));
        end else begin
            valid    <= 1'b0;
        end
    end

    // R11: the quotient strobe never lasts two cycles
    a_r11_div_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

endmodule

// File: rtl/iqc_coef_fmt.sv
module iqc_coef_fmt #(
    parameter int W = 32,
    parameter int C = 7
) (
    input  logic [W-1:0] q_phase,
    input  logic         corr_neg,
    input  logic [W-1:0] q_gain,
    output logic [C-1:0] ph_coef,
    output logic [C-1:0] gn_coef
);

    localparam int LIM = (1 << (C - 1)) - 1;
    localparam int OFF = 1 << (C - 1);
    localparam int NEG_LIM = (1 << C) - LIM;

    logic [C-1:0] ph_mag;

    always_comb begin
        // Clamp first, then apply the sign convention.
        ph_mag  = (q_phase >= W'(LIM)) ? C'(LIM) : q_phase[C-1:0];
        ph_coef = corr_neg ? ph_mag : (C'(0) - ph_mag);

        if (q_gain >= W'(LIM + OFF)) begin
            gn_coef = C'(LIM);
        end else if (q_gain <= W'(OFF - LIM)) begin
            gn_coef = C'(NEG_LIM);
        end else begin
            gn_coef = q_gain[C-1:0] - C'(OFF);
        end
    end

endmodule

// File: rtl/iqc_calc.sv
module iqc_calc
    import iqc_pkg::*;
#(
    parameter int ACC_W    = 32,
    parameter int COEF_W   = 7,
    parameter int LOG_W    = 4,
    parameter int CNT_W    = 8,
    parameter int PH_SHIFT = 8,
    parameter int GN_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LOG_W-1:0]  log_cnt,
    input  logic [CNT_W-1:0]  num_meas,
    input  logic              in_valid,
    input  logic [ACC_W-1:0]  in_pwr_i,
    input  logic [ACC_W-1:0]  in_pwr_q,
    input  logic [ACC_W-1:0]  in_corr,
    output logic [COEF_W-1:0] coef_phase,
    output logic [COEF_W-1:0] coef_gain,
    output logic              corr_en,
    output logic              done,
    output logic              skipped
);

    localparam int SAMP_W = (1 << LOG_W) + 1;
    localparam logic [ACC_W-1:0] SIGN_EDGE = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [COEF_W-1:0] BAD_CODE = {1'b1, {(COEF_W-1){1'b0}}};

    iqc_state_e state, nxt;

    logic [LOG_W-1:0]  lat_lc;
    logic [CNT_W-1:0]  tgt;
    logic [SAMP_W-1:0] samp_cnt;
    logic [CNT_W-1:0]  intv_cnt;
    logic [LOG_W:0]    shamt;
    logic [SAMP_W-1:0] samp_last;

    logic [ACC_W-1:0]  acc_in  [NUM_ACC];
    logic [ACC_W-1:0]  acc_sum [NUM_ACC];
    logic              acc_en;

    logic              corr_neg;
    logic [ACC_W-1:0]  corr_mag;
    logic [ACC_W-1:0]  half_sum;
    logic [ACC_W-1:0]  den_ph;
    logic [ACC_W-1:0]  den_gn;
    logic              den_zero;
    logic              beat_last;

    logic              div_start;
    logic [ACC_W-1:0]  div_num;
    logic [ACC_W-1:0]  div_den;
    logic [ACC_W-1:0]  div_quot;
    logic              div_valid;
    logic [ACC_W-1:0]  q_ph;
    logic [ACC_W-1:0]  q_gn;
    logic [COEF_W-1:0] fmt_ph;
    logic [COEF_W-1:0] fmt_gn;

    // ---------------- accumulators ----------------
    assign acc_in[ACC_PI] = in_pwr_i;
    assign acc_in[ACC_PQ] = in_pwr_q;
    assign acc_in[ACC_CR] = in_corr;
    assign acc_en = (state == ST_COLLECT) && in_valid && !start;

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        iqc_accum #(.W(ACC_W)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (start),
            .en    (acc_en),
            .din   (acc_in[g]),
            .sum   (acc_sum[g])
        );
    end

    // ---------------- window counting ----------------
    always_comb begin
        shamt     = {1'b0, lat_lc} + (LOG_W + 1)'(1);
        samp_last = (SAMP_W'(1) << shamt) - SAMP_W'(1);
        beat_last = acc_en && (samp_cnt == samp_last) &&
                    (intv_cnt == tgt - CNT_W'(1));
    end

    // ---------------- normalisation ----------------
    always_comb begin
        corr_neg = acc_sum[ACC_CR] > SIGN_EDGE;
        corr_mag = corr_neg ? (~acc_sum[ACC_CR] + ACC_W'(1)) : acc_sum[ACC_CR];
        half_sum = (acc_sum[ACC_PI] >> 1) + (acc_sum[ACC_PQ] >> 1);
        den_ph   = half_sum >> PH_SHIFT;
        den_gn   = acc_sum[ACC_PQ] >> GN_SHIFT;
        den_zero = (den_ph == '0) || (den_gn == '0);
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        if (start) begin
            nxt = ST_COLLECT;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_COLLECT: if (beat_last) nxt = ST_PREP;
                ST_PREP:    nxt = den_zero ? ST_SKIP : ST_DIV_PH;
                ST_DIV_PH:  if (div_valid) nxt = ST_DIV_GN;
                ST_DIV_GN:  if (div_valid) nxt = ST_FINISH;
                ST_FINISH:  nxt = ST_IDLE;
                ST_SKIP:    nxt = ST_IDLE;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // ---------------- divider sequencing ----------------
    always_comb begin
        div_start = !start &&
                    (((state == ST_PREP) && !den_zero) ||
                     ((state == ST_DIV_PH) && div_valid));
        div_num   = (state == ST_PREP) ? corr_mag : acc_sum[ACC_PI];
        div_den   = (state == ST_PREP) ? den_ph   : den_gn;
    end

    iqc_divider #(.W(ACC_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_num),
        .divisor  (div_den),
        .quotient (div_quot),
        .valid    (div_valid)
    );

    iqc_coef_fmt #(.W(ACC_W), .C(COEF_W)) u_fmt (
        .q_phase  (q_ph),
        .corr_neg (corr_neg),
        .q_gain   (q_gn),
        .ph_coef  (fmt_ph),
        .gn_coef  (fmt_gn)
    );

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_lc   <= '0;
            tgt      <= CNT_W'(1);
            samp_cnt <= '0;
            intv_cnt <= '0;
            q_ph     <= '0;
            q_gn     <= '0;
        end else if (start) begin
            lat_lc   <= log_cnt;
            tgt      <= (num_meas == '0) ? CNT_W'(1) : num_meas;
            samp_cnt <= '0;
            intv_cnt <= '0;
        end else begin
            if (acc_en) begin
                if (samp_cnt == samp_last) begin
                    samp_cnt <= '0;
                    intv_cnt <= intv_cnt + CNT_W'(1);
                end else begin
                    samp_cnt <= samp_cnt + SAMP_W'(1);
                end
            end
            if ((state == ST_DIV_PH) && div_valid) q_ph <= div_quot;
            if ((state == ST_DIV_GN) && div_valid) q_gn <= div_quot;
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_phase <= '0;
            coef_gain  <= '0;
            corr_en    <= 1'b0;
            done       <= 1'b0;
            skipped    <= 1'b0;
        end else begin
            done    <= (state == ST_FINISH) || (state == ST_SKIP);
            skipped <= (state == ST_SKIP);
            if (state == ST_FINISH) begin
                coef_phase <= fmt_ph;
                coef_gain  <= fmt_gn;
                corr_en    <= 1'b1;
            end
        end
    end

    // ---------------- assertions ----------------
    // R11: completion pulse lasts a single cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a skip is always reported together with done
    a_r7_skip_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        skipped |-> done);

    // R7: a skip leaves the coefficients untouched
    a_r7_skip_holds: assert property (@(posedge clk) disable iff (!rst_n)
        skipped |-> ($stable(coef_phase) && $stable(coef_gain)));

    // R10: coefficients move only alongside done
    a_r10_coef_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(coef_phase) && $stable(coef_gain)));

    // R10: the unbalanced code never reaches the outputs
    a_r10_no_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !skipped) |-> ((coef_phase != BAD_CODE) && (coef_gain != BAD_CODE)));

    // R12: enable is sticky
    a_r12_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        corr_en |=> corr_en);

    // R6: the divider is never launched on a zero divisor
    a_r6_no_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> (div_den != '0));

endmodule

// File: tb/iqc_calc_tb.sv
`timescale 1ns/1ps
module iqc_calc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  log_cnt = '0;
    logic [7:0]  num_meas = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_pwr_i = '0;
    logic [31:0] in_pwr_q = '0;
    logic [31:0] in_corr = '0;
    logic [6:0]  coef_phase;
    logic [6:0]  coef_gain;
    logic        corr_en;
    logic        done;
    logic        skipped;

    int n_chk = 0;
    int n_bad = 0;
    bit [31:0] s_i, s_q, s_c;

    always #2.5 clk = ~clk;

    iqc_calc u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .log_cnt(log_cnt),
        .num_meas(num_meas), .in_valid(in_valid), .in_pwr_i(in_pwr_i),
        .in_pwr_q(in_pwr_q), .in_corr(in_corr), .coef_phase(coef_phase),
        .coef_gain(coef_gain), .corr_en(corr_en), .done(done), .skipped(skipped)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model(input bit [31:0] si, input bit [31:0] sq, input bit [31:0] sc,
                         output bit skip, output bit [6:0] ph, output bit [6:0] gn);
        bit neg;
        bit [31:0] mag, dph, dgn;
        longint qp, qg;
        int p, g;
        neg  = sc > 32'h8000_0000;
        mag  = neg ? (~sc + 32'd1) : sc;
        dph  = ((si >> 1) + (sq >> 1)) >> 8;
        dgn  = sq >> 6;
        skip = (dph == 0) || (dgn == 0);
        ph = '0;
        gn = '0;
        if (!skip) begin
            qp = longint'(mag) / longint'(dph);
            qg = longint'(si) / longint'(dgn);
            p = (qp >= 63) ? 63 : int'(qp);
            if (!neg) p = -p;
            if (qg >= 127) g = 63;
            else begin
                g = int'(qg) - 64;
                if (g < -63) g = -63;
            end
            ph = p[6:0];
            gn = g[6:0];
        end
    endtask

    task automatic do_start(input int lc, input int nm);
        @(negedge clk);
        start = 1'b1;
        log_cnt = 4'(lc);
        num_meas = 8'(nm);
        @(negedge clk);
        start = 1'b0;
        s_i = '0; s_q = '0; s_c = '0;
    endtask

    task automatic beat(input bit [31:0] vi, input bit [31:0] vq, input bit [31:0] vc);
        @(negedge clk);
        in_valid = 1'b1;
        in_pwr_i = vi; in_pwr_q = vq; in_corr = vc;
        s_i += vi; s_q += vq; s_c += vc;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_pwr_i = 32'hDEAD_BEEF; in_pwr_q = 32'h0BAD_F00D; in_corr = 32'h7777_0001;
    endtask

    task automatic idle_junk(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_pwr_i = 32'hFFFF_0000 + 32'(k); in_pwr_q = 32'h1234_5678; in_corr = 32'h8000_0007;
        end
    endtask

    // Called right after the edge that took the last beat.
    task automatic finish_check(input string tag, input bit [6:0] prev_ph, input bit [6:0] prev_gn,
                                input bit prev_en);
        bit skip;
        bit [6:0] eph, egn;
        int lat;
        lat = 0;
        model(s_i, s_q, s_c, skip, eph, egn);
        for (int k = 1; k <= 200; k++) begin
            @(posedge clk);
            #1;
            if (done) begin
                lat = k;
                break;
            end
        end
        chk(skip ? {tag, " R7 latency"} : {tag, " R11 latency"}, 32'(lat), skip ? 32'd2 : 32'd68);
        chk({tag, " R7 skipped flag"}, 32'(skipped), 32'(skip));
        if (skip) begin
            chk({tag, " R7 phase held"}, 32'(coef_phase), 32'(prev_ph));
            chk({tag, " R7 gain held"}, 32'(coef_gain), 32'(prev_gn));
            chk({tag, " R12 enable unchanged"}, 32'(corr_en), 32'(prev_en));
        end else begin
            chk({tag, " R8 phase"}, 32'(coef_phase), 32'(eph));
            chk({tag, " R9 gain"}, 32'(coef_gain), 32'(egn));
            chk({tag, " R12 enable"}, 32'(corr_en), 32'd1);
        end
        @(posedge clk);
        #1;
        chk({tag, " R11 done one cycle"}, 32'(done), 32'd0);
    endtask

    task automatic run_calc(input string tag, input int lc, input int nm, input int nb,
                            input bit [31:0] vi, input bit [31:0] vq, input bit [31:0] vc,
                            input bit [31:0] vc_last);
        bit [6:0] pph, pgn;
        bit pen;
        pph = coef_phase; pgn = coef_gain; pen = corr_en;
        do_start(lc, nm);
        for (int k = 0; k < nb; k++) begin
            beat(vi, vq, (k == nb - 1) ? vc_last : vc);
            if (k != nb - 1) idle_junk(1);
        end
        finish_check(tag, pph, pgn, pen);
    endtask

    task automatic t_reset;
        chk("R1 phase at reset", 32'(coef_phase), 32'd0);
        chk("R1 gain at reset", 32'(coef_gain), 32'd0);
        chk("R1 done at reset", 32'(done), 32'd0);
        chk("R1 skipped at reset", 32'(skipped), 32'd0);
        chk("R1 enable at reset", 32'(corr_en), 32'd0);
    endtask

    task automatic t_window_length;
        bit [6:0] pph, pgn;
        bit pen;
        bit early;
        pph = coef_phase; pgn = coef_gain; pen = corr_en;
        do_start(2, 1);
        log_cnt = 4'd0;      // R2: ignored until the next start
        num_meas = 8'd5;
        for (int k = 0; k < 7; k++) begin
            beat(32'd50000, 32'd50000, 32'hFFFF_F448);
            idle_junk(1);
        end
        early = 1'b0;
        for (int k = 0; k < 80; k++) begin
            @(posedge clk);
            #1;
            if (done) early = 1'b1;
        end
        chk("R3 no result before last beat", 32'(early), 32'd0);
        beat(32'd50000, 32'd50000, 32'hFFFF_F448);
        finish_check("R3 eight-beat interval", pph, pgn, pen);
    endtask

    task automatic t_restart;
        do_start(0, 1);
        beat(32'h4000_0000, 32'd1, 32'h4000_0000);
        idle_junk(2);
        // R2: a new start clears the partial window
        run_calc("R2 restart", 0, 1, 2, 32'd200000, 32'd200000, 32'd3000, 32'd3000);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        run_calc("R8/R9 positive corr", 0, 2, 4, 32'd110000, 32'd100000, 32'd5000, 32'd5000);
        run_calc("R5 negative corr", 0, 2, 4, 32'd90000, 32'd100000, 32'hFFFF_EC78, 32'hFFFF_EC78);
        run_calc("R8 clamp high", 0, 2, 4, 32'd1000000, 32'd100000, 32'h1000_0000, 32'h1000_0000);
        run_calc("R9 clamp low", 0, 2, 4, 32'd1000, 32'd100000, 32'hF000_0000, 32'hF000_0000);
        run_calc("R5 exact edge", 0, 2, 4, 32'd100000, 32'd100000, 32'h2000_0000, 32'h2000_0000);
        run_calc("R5 past edge", 0, 2, 4, 32'd100000, 32'd100000, 32'h2000_0000, 32'h2000_0001);
        run_calc("R7 gain den zero", 0, 2, 4, 32'd500000, 32'd10, 32'd77, 32'd77);
        run_calc("R7 phase den zero", 0, 2, 4, 32'd0, 32'd100, 32'd77, 32'd77);
        run_calc("R4 wrap", 0, 1, 2, 32'h9000_0000, 32'h1000_0000, 32'd4096, 32'd4096);
        run_calc("R3 zero count", 0, 0, 2, 32'd300000, 32'd250000, 32'hFFFF_0000, 32'hFFFF_0000);
        t_window_length();
        t_restart();
        run_calc("R10 mid gain", 1, 3, 12, 32'd80000, 32'd80000, 32'd700, 32'd700);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule